// File: doc/BRIEF.md
# Complementary Output Stage with Dead-Time

This block sits between two raw pulse-width modulated channels and a pair of output pins, one driving a high-side switch and one driving a low-side switch. A mode input selects how the pins are fed. In independent mode each pin simply carries one channel. In complementary mode both pins come from channel 0. The high pin carries the signal and the low pin carries its inverse. After every transition of channel 0 both pins are held inactive for a programmable number of clock cycles, so that the two switches of a half bridge never conduct together.

The dead-time length is an input count of clock cycles; zero disables insertion. Both outputs are registered, so every output reflects the inputs sampled at the previous clock edge. The block does not generate the raw PWM waveforms.

Top module: `pwm_pair_out`

## Requirements
- R1: While rst_ni is low, hi_o and lo_o are both 0.
- R2: With mode_i = 0 (independent), hi_o equals pwm0_i and lo_o equals pwm1_i as sampled at the previous clock edge.
- R3: With mode_i = 0, dt_cnt_i has no effect: edges of pwm0_i and pwm1_i reach the pins after the single register cycle, whatever the dead-time value.
- R4: With mode_i = 1 (complementary), pwm1_i has no effect on either output.
- R5: With mode_i = 1, hi_o and lo_o are never 1 in the same cycle.
- R6: In complementary mode, after a rising edge of pwm0_i is sampled, both outputs stay 0 for dt_cnt_i cycles, after which hi_o is 1 while pwm0_i stays high.
- R7: In complementary mode, after a falling edge of pwm0_i is sampled, both outputs stay 0 for dt_cnt_i cycles, after which lo_o is 1 while pwm0_i stays low.
- R8: If pwm0_i changes again before the dead-time has run out, the dead-time restarts from the full count at the new edge and both outputs remain 0 throughout.
- R9: With dt_cnt_i = 0 in complementary mode, hi_o follows pwm0_i and lo_o follows its inverse with only the one register cycle and no blanking.
- R10: Entering complementary mode while pwm0_i is steady inserts no dead-time; the pins take the complementary values at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = independent, 1 = complementary |
| dt_cnt_i | input | DT_W | Dead-time length in clock cycles, 0 = none |
| pwm0_i | input | 1 | Raw PWM channel 0 |
| pwm1_i | input | 1 | Raw PWM channel 1 |
| hi_o | output | 1 | High-side pin |
| lo_o | output | 1 | Low-side pin |

## Verification
The bench sweeps dead-time values against pulse widths both shorter and longer than the dead-time. This exposes an off-by-one blank length (a pin turning on a cycle early or late) and a counter that keeps running instead of reloading when a pulse is shorter than the dead-time, which would let a pin turn on in the middle of a glitch. Mode switches with channel 0 held steady catch a design that sees a false edge and blanks the pins. Channel 1 and the dead-time input are toggled where they must be ignored, so a leaky multiplexer or a dead-time that is active in independent mode shows up as a wrong pin value.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  typedef enum logic {
    MODE_INDEP = 1'b0,
    MODE_COMP  = 1'b1
  } pair_mode_e;

  localparam int unsigned DT_W_DEF = 8;
endpackage

// File: rtl/pwm_dt_timer.sv
module pwm_dt_timer #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            src_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            edge_o,
  output logic            idle_o
);
  localparam logic [DT_W-1:0] CNT_ZERO = '0;

  logic            src_q;
  logic [DT_W-1:0] cnt_q, cnt_n;

  assign edge_o = (src_i != src_q);

  // counter is parked at zero whenever dead-time is not in use
  always_comb begin
    if (!en_i)              cnt_n = CNT_ZERO;
    else if (edge_o)        cnt_n = dt_i;
    else if (cnt_q != '0)   cnt_n = cnt_q - 1'b1;
    else                    cnt_n = CNT_ZERO;
  end

  assign idle_o = (cnt_n == CNT_ZERO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= 1'b0;
      cnt_q <= CNT_ZERO;
    end else begin
      src_q <= src_i;
      cnt_q <= cnt_n;
    end
  end

  // R8: a new edge with a non-zero count always arms the blanking interval
  p_reload_on_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && edge_o && dt_i != '0) |=> (cnt_q != '0));

  // R3: counter stays parked while disabled
  p_parked_when_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_pair_sel.sv
module pwm_pair_sel
  import pwm_pair_pkg::*;
(
  input  pair_mode_e mode_i,
  input  logic       ch0_i,
  input  logic       ch1_i,
  input  logic       idle_i,
  output logic       hi_o,
  output logic       lo_o
);
  always_comb begin
    unique case (mode_i)
      MODE_COMP: begin
        hi_o = ch0_i & idle_i;
        lo_o = ~ch0_i & idle_i;
      end
      default: begin
        hi_o = ch0_i;
        lo_o = ch1_i;
      end
    endcase
  end
endmodule

// File: rtl/pwm_pair_out.sv
module pwm_pair_out
  import pwm_pair_pkg::*;
#(
  parameter int unsigned DT_W = DT_W_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_i,
  input  logic [DT_W-1:0] dt_cnt_i,
  input  logic            pwm0_i,
  input  logic            pwm1_i,
  output logic            hi_o,
  output logic            lo_o
);
  pair_mode_e mode;
  logic       dt_edge, dt_idle;
  logic       hi_n, lo_n;
  logic       hi_q, lo_q, mode_q, past_ok;

  assign mode = pair_mode_e'(mode_i);

  pwm_dt_timer #(.DT_W(DT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mode == MODE_COMP),
    .src_i  (pwm0_i),
    .dt_i   (dt_cnt_i),
    .edge_o (dt_edge),
    .idle_o (dt_idle)
  );

  pwm_pair_sel u_sel (
    .mode_i (mode),
    .ch0_i  (pwm0_i),
    .ch1_i  (pwm1_i),
    .idle_i (dt_idle),
    .hi_o   (hi_n),
    .lo_o   (lo_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
      mode_q  <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      hi_q    <= hi_n;
      lo_q    <= lo_n;
      mode_q  <= mode_i;
      past_ok <= 1'b1;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  p_no_overlap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> !(hi_o && lo_o));

  p_indep_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !mode_q) |-> (hi_o == $past(pwm0_i) && lo_o == $past(pwm1_i)));

  p_blank_on_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && dt_edge && dt_cnt_i != '0) |=> (!hi_o && !lo_o));

  p_zero_dt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && dt_cnt_i == '0 && (hi_o || lo_o)) |=>
      (hi_o == $past(pwm0_i) && lo_o == !$past(pwm0_i)));
endmodule

// File: tb/pwm_pair_out_bench.sv
`timescale 1ns/1ps
module pwm_pair_out_bench;
  localparam int DT_W = 8;
  localparam int BIG  = 100000;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            mode = 1'b0;
  logic [DT_W-1:0] dt = '0;
  logic            p0 = 1'b0, p1 = 1'b0;
  logic            hi, lo;

  int checks = 0, errors = 0;
  int run = BIG, dt_edge = 0;
  logic prev_s = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_pair_out #(.DT_W(DT_W)) u_pwm_pair_out (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .dt_cnt_i(dt),
    .pwm0_i(p0), .pwm1_i(p1), .hi_o(hi), .lo_o(lo)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic step(input string tag, input logic m, input int d, input logic a, input logic b);
    logic eh, el;
    @(negedge clk);
    mode = m; dt = d[DT_W-1:0]; p0 = a; p1 = b;
    if (!m) run = BIG;
    else if (a != prev_s) begin run = 1; dt_edge = d; end
    else if (run < BIG) run++;
    prev_s = a;
    eh = m ? (a && run > dt_edge) : a;
    el = m ? (!a && run > dt_edge) : b;
    @(posedge clk); #1;
    chk(tag, hi, eh, "hi_o");
    chk(tag, lo, el, "lo_o");
    if (m) chk("R5", hi & lo, 1'b0, "overlap");
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", hi, 1'b0, "hi_o in reset");
    chk("R1", lo, 1'b0, "lo_o in reset");
    @(negedge clk); rst_ni = 1'b1;

    // R2 / R3: every input pair, dead-time values that must be ignored
    for (int d = 0; d < 6; d++)
      for (int k = 0; k < 8; k++)
        step(d == 0 ? "R2" : "R3", 1'b0, d * 3, k[0], k[1]);

    // R6 / R7 / R4: dead-time against half-periods, channel 1 random
    for (int d = 0; d < 5; d++)
      for (int hp = 1; hp < 8; hp++)
        for (int per = 0; per < 3; per++) begin
          for (int i = 0; i < hp; i++) step("R6", 1'b1, d, 1'b1, rnd());
          for (int i = 0; i < hp; i++) step("R7", 1'b1, d, 1'b0, rnd());
        end

    // R8: glitches shorter than the dead-time keep restarting it
    for (int g = 1; g < 6; g++) begin
      for (int i = 0; i < g; i++) step("R8", 1'b1, 5, 1'b1, 1'b0);
      for (int i = 0; i < g; i++) step("R8", 1'b1, 5, 1'b0, 1'b1);
      for (int i = 0; i < 8; i++) step("R8", 1'b1, 5, 1'b0, 1'b0);
    end

    // R9: zero dead-time
    for (int i = 0; i < 40; i++) step("R9", 1'b1, 0, rnd(), rnd());

    // R10: enter complementary mode with channel 0 held
    for (int v = 0; v < 2; v++) begin
      for (int i = 0; i < 4; i++) step("R10", 1'b0, 4, v[0], 1'b1);
      for (int i = 0; i < 6; i++) step("R10", 1'b1, 4, v[0], 1'b1);
    end

    // largest dead-time
    step("R6", 1'b1, 255, 1'b1, 1'b0);
    for (int i = 0; i < 260; i++) step("R6", 1'b1, 255, 1'b1, 1'b0);
    for (int i = 0; i < 260; i++) step("R7", 1'b1, 255, 1'b0, 1'b0);

    // mixed random chunks
    for (int c = 0; c < 40; c++) begin
      logic m;
      int d;
      m = rnd();
      d = {29'd0, rnd(), rnd(), rnd()};
      for (int i = 0; i < 25; i++) step(m ? "R6" : "R2", m, d, rnd() & rnd() | (i > 12), rnd());
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule